// File: doc/BRIEF.md
# Selectable Self-Test Symbol Generator and Checker

This block produces and verifies a built-in self-test stream on a 10-bit parallel symbol path, moving one symbol per clock. A 3-bit select picks the stream. It can be a constant symbol, a pair of complementary symbols sent in turn, or a PRBS7 stream that advances ten bits per symbol. One select value corrupts the transmitted pair on purpose while the checker still expects the clean pair. A healthy checker must then count errors on a perfect loop, which shows that the comparison logic really works.

A separate transmit-test enable overrides the self-test source. It sends a programmable 20-bit word as two 10-bit halves in turn. The receive side compares incoming symbols against its own prediction of the selected stream. It keeps a saturating mismatch counter and a sticky error flag. In normal use the transmit output is looped back through the serial link and returns on the receive input.

Top module: `selftest_symbol_engine`

## Requirements
- R1: After reset, txValid is 0, txSym is 0, errCount is 0, errFlag is 0, and the programmed 20-bit word holds 0x003FF.
- R2: When modeSel[2:1] is 00 and txTestEn is 0, txValid is 0 and txSym is 0 after the next edge. Received symbols are not compared and leave errCount unchanged.
- R3: Select 100 transmits 0x000 on every cycle, select 010 transmits 0x3FF, and select 110 transmits 0x155. Each value is written with bit 9 as the most significant bit. The checker expects the same constant.
- R4: Select 101 transmits 0x0FA and 0x305 in turn, starting with 0x0FA at the first edge that samples the new select. The checker expects this same pair.
- R5: Select 011 transmits the R4 pair with bit 0 inverted (0x0FB, 0x304), while the checker expects the clean R4 pair. On a direct loop, errCount therefore rises by one on every symbol, beginning with the second edge after the select changes.
- R6: Select 111 transmits PRBS7 with polynomial x^7+x^6+1 and a seed of all ones. Ten generator bits form each symbol, with the first bit in bit 9. The first symbol after the select changes is the first ten generator bits.
- R7: In select 111, the first valid received symbol after a select change seeds the checker: its bits [6:0] become the predictor state, and that symbol is not compared. After that, the predictor advances only on valid symbols and counts each symbol that mismatches.
- R8: In select 101 or 011, the checker stays unaligned until a valid symbol whose bits [9:1] equal those of 0x0FA or 0x305. That symbol and every later one are compared in full against the alternating pair. Symbols that arrive before alignment are not counted.
- R9: While txTestEn is 1, txValid is 1 whatever the select. txSym alternates between word bits [19:10] and word bits [9:0], starting with [19:10] at the edge where txTestEn rises.
- R10: patWrEn loads patWrData into the programmed word at the clock edge.
- R11: errCount rises by one for each compared symbol that mismatches and holds at 0xFFFF. It clears to 0 at the edge where modeSel differs from its value in the previous cycle. That edge also drops alignment and compares nothing.
- R12: errFlag sets at the edge that samples a mismatch and stays set until errClr is 1 at an edge with no mismatch. A select change does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 3 | Self-test stream select |
| txTestEn | input | 1 | Send the programmed word instead of the self-test stream |
| patWrEn | input | 1 | Load strobe for the programmed word |
| patWrData | input | 20 | New programmed word |
| errClr | input | 1 | Synchronous clear of the error flag |
| rxSym | input | 10 | Received symbol |
| rxValid | input | 1 | Received symbol is present |
| txSym | output | 10 | Transmitted symbol, registered |
| txValid | output | 1 | Transmitted symbol is present |
| errCount | output | 16 | Saturating mismatch count |
| errFlag | output | 1 | Sticky mismatch indication |

## Verification
Each mode drives a different visible effect, so a wrong internal state shows up quickly at the ports. A wrong transmit phase or generator state changes txSym at the very next edge. A predictor that has lost step with the stream shows up at the following valid symbol: errCount rises on a clean loop. Alignment and seeding faults are the slowest to appear. They show only on the second valid symbol after a select change, which is why the bench runs a clean loop, a deliberately corrupted loop and hand-driven streams with gaps and single flipped bits. Saturation is reached by running the corrupted-pair mode for more than 65535 symbols.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
  localparam int SYM_W = 10;
  localparam int PRBS_ORD = 7;
  localparam logic [SYM_W-1:0] PAIR_LO = 10'b0011111010;

  typedef enum logic [1:0] {PAT_OFF, PAT_FIXED, PAT_PAIR, PAT_PRBS} patKind_e;
  typedef enum logic [1:0] {FIX_ZERO, FIX_ONES, FIX_ALT} fixKind_e;

  typedef struct packed {
    patKind_e kind;
    fixKind_e fix;
    logic     flipLsb;
    logic     txTest;
    logic     txRestart;
    logic     chkClear;
  } ctrlStrb_t;
endpackage

// File: rtl/selftest_ctrl.sv
module selftest_ctrl
  import selftest_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic [2:0] modeSel,
  input  logic      txTestEn,
  output ctrlStrb_t strb
);
  logic [2:0] prevMode;
  logic       prevTxt;
  logic       modeChange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevMode <= 3'b000;
      prevTxt  <= 1'b0;
    end else begin
      prevMode <= modeSel;
      prevTxt  <= txTestEn;
    end
  end

  assign modeChange = (modeSel != prevMode);

  always_comb begin
    strb = '0;
    strb.kind = PAT_OFF;
    strb.fix  = FIX_ZERO;
    unique case (modeSel)
      3'b100:  begin strb.kind = PAT_FIXED; strb.fix = FIX_ZERO; end
      3'b010:  begin strb.kind = PAT_FIXED; strb.fix = FIX_ONES; end
      3'b110:  begin strb.kind = PAT_FIXED; strb.fix = FIX_ALT;  end
      3'b101:  strb.kind = PAT_PAIR;
      3'b011:  begin strb.kind = PAT_PAIR; strb.flipLsb = 1'b1; end
      3'b111:  strb.kind = PAT_PRBS;
      default: strb.kind = PAT_OFF;
    endcase
    strb.txTest    = txTestEn;
    strb.txRestart = modeChange || (txTestEn != prevTxt);
    strb.chkClear  = modeChange;
  end
endmodule

// File: rtl/selftest_datapath.sv
module selftest_datapath
  import selftest_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [2*SYM_W-1:0] PAT_RESET = 20'h003FF
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic             patWrEn,
  input  logic [2*SYM_W-1:0] patWrData,
  input  logic             errClr,
  input  logic [SYM_W-1:0] rxSym,
  input  logic             rxValid,
  output logic [SYM_W-1:0] txSym,
  output logic             txValid,
  output logic [CNT_W-1:0] errCount,
  output logic             errFlag
);
  localparam int PAT_W = 2 * SYM_W;
  localparam logic [SYM_W-1:0] PAIR_HI = ~PAIR_LO;
  localparam logic [PRBS_ORD-1:0] PRBS_SEED = '1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [SYM_W-1:0] LSB_MASK = SYM_W'(1);

  function automatic logic [SYM_W+PRBS_ORD-1:0] prbsStep(input logic [PRBS_ORD-1:0] stIn);
    logic [PRBS_ORD-1:0] st;
    logic [SYM_W-1:0]    outSym;
    logic                fb;
    st = stIn;
    outSym = '0;
    for (int i = 0; i < SYM_W; i++) begin
      fb = st[PRBS_ORD-1] ^ st[PRBS_ORD-2];
      st = {st[PRBS_ORD-2:0], fb};
      outSym[SYM_W-1-i] = fb;
    end
    return {outSym, st};
  endfunction

  function automatic logic [SYM_W-1:0] fixedSym(input fixKind_e f);
    logic [SYM_W-1:0] v;
    v = '0;
    case (f)
      FIX_ONES: v = '1;
      FIX_ALT:  for (int i = 0; i < SYM_W; i++) v[i] = (i % 2 == 0);
      default:  v = '0;
    endcase
    return v;
  endfunction

  // programmed word
  logic [PAT_W-1:0] patReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        patReg <= PAT_RESET;
    else if (patWrEn) patReg <= patWrData;
  end

  // transmit side
  logic                txPhase, phaseNow;
  logic [PRBS_ORD-1:0] txPrbs, prbsBase, prbsTxState, txPrbsNext;
  logic [SYM_W-1:0]    prbsTxSym, txSymNext;
  logic                txValidNext;

  always_comb begin
    phaseNow = strb.txRestart ? 1'b0 : txPhase;
    prbsBase = strb.txRestart ? PRBS_SEED : txPrbs;
    {prbsTxSym, prbsTxState} = prbsStep(prbsBase);
    txSymNext   = '0;
    txValidNext = 1'b0;
    txPrbsNext  = PRBS_SEED;
    if (strb.txTest) begin
      txValidNext = 1'b1;
      txSymNext   = phaseNow ? patReg[SYM_W-1:0] : patReg[PAT_W-1:SYM_W];
    end else begin
      case (strb.kind)
        PAT_FIXED: begin
          txValidNext = 1'b1;
          txSymNext   = fixedSym(strb.fix);
        end
        PAT_PAIR: begin
          txValidNext = 1'b1;
          txSymNext   = (phaseNow ? PAIR_HI : PAIR_LO) ^ (strb.flipLsb ? LSB_MASK : '0);
        end
        PAT_PRBS: begin
          txValidNext = 1'b1;
          txSymNext   = prbsTxSym;
          txPrbsNext  = prbsTxState;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSym   <= '0;
      txValid <= 1'b0;
      txPhase <= 1'b0;
      txPrbs  <= PRBS_SEED;
    end else begin
      txSym   <= txSymNext;
      txValid <= txValidNext;
      txPhase <= ~phaseNow;
      txPrbs  <= txPrbsNext;
    end
  end

  // receive side
  logic                rxLocked, lockNext;
  logic                rxPhase, rxPhaseNext;
  logic [PRBS_ORD-1:0] chkState, chkStateNext, prbsExpState;
  logic [SYM_W-1:0]    prbsExpSym, expSym;
  logic                doCmp, mismatch, alignLo, alignHi;

  always_comb begin
    {prbsExpSym, prbsExpState} = prbsStep(chkState);
    alignLo      = (rxSym[SYM_W-1:1] == PAIR_LO[SYM_W-1:1]);
    alignHi      = (rxSym[SYM_W-1:1] == PAIR_HI[SYM_W-1:1]);
    expSym       = '0;
    doCmp        = 1'b0;
    lockNext     = rxLocked;
    rxPhaseNext  = rxPhase;
    chkStateNext = chkState;
    if (strb.chkClear) begin
      lockNext    = 1'b0;
      rxPhaseNext = 1'b0;
    end else if (rxValid) begin
      case (strb.kind)
        PAT_FIXED: begin
          doCmp  = 1'b1;
          expSym = fixedSym(strb.fix);
        end
        PAT_PAIR: begin
          if (rxLocked) begin
            doCmp       = 1'b1;
            expSym      = rxPhase ? PAIR_HI : PAIR_LO;
            rxPhaseNext = ~rxPhase;
          end else if (alignLo || alignHi) begin
            doCmp       = 1'b1;
            expSym      = alignLo ? PAIR_LO : PAIR_HI;
            lockNext    = 1'b1;
            rxPhaseNext = alignLo;
          end
        end
        PAT_PRBS: begin
          if (rxLocked) begin
            doCmp        = 1'b1;
            expSym       = prbsExpSym;
            chkStateNext = prbsExpState;
          end else begin
            chkStateNext = rxSym[PRBS_ORD-1:0];
            lockNext     = 1'b1;
          end
        end
        default: ;
      endcase
    end
    mismatch = doCmp && (rxSym != expSym);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxLocked <= 1'b0;
      rxPhase  <= 1'b0;
      chkState <= PRBS_SEED;
      errCount <= '0;
      errFlag  <= 1'b0;
    end else begin
      rxLocked <= lockNext;
      rxPhase  <= rxPhaseNext;
      chkState <= chkStateNext;
      if (strb.chkClear)                       errCount <= '0;
      else if (mismatch && errCount != CNT_MAX) errCount <= errCount + 1'b1;
      if (mismatch)    errFlag <= 1'b1;
      else if (errClr) errFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/selftest_symbol_engine.sv
module selftest_symbol_engine
  import selftest_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [19:0] PAT_RESET = 20'h003FF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  modeSel,
  input  logic        txTestEn,
  input  logic        patWrEn,
  input  logic [19:0] patWrData,
  input  logic        errClr,
  input  logic [9:0]  rxSym,
  input  logic        rxValid,
  output logic [9:0]  txSym,
  output logic        txValid,
  output logic [CNT_W-1:0] errCount,
  output logic        errFlag
);
  ctrlStrb_t strb;

  selftest_ctrl ctrlInst (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .txTestEn(txTestEn), .strb(strb)
  );

  selftest_datapath #(.CNT_W(CNT_W), .PAT_RESET(PAT_RESET)) dpInst (
    .clk(clk), .rstN(rstN), .strb(strb), .patWrEn(patWrEn), .patWrData(patWrData),
    .errClr(errClr), .rxSym(rxSym), .rxValid(rxValid), .txSym(txSym),
    .txValid(txValid), .errCount(errCount), .errFlag(errFlag)
  );
endmodule

// File: rtl/selftest_symbol_engine_chk.sv
module selftest_symbol_engine_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       modeSel,
  input logic             txTestEn,
  input logic             errClr,
  input logic [9:0]       txSym,
  input logic             txValid,
  input logic [CNT_W-1:0] errCount,
  input logic             errFlag
);
  // R2
  idle_no_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel[2:1] == 2'b00 && !txTestEn) |=> !txValid);

  // R9
  txtest_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    txTestEn |=> txValid);

  // R3
  ones_symbol_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'b010 && !txTestEn) |=> (txSym == 10'h3FF));

  // R11
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(errCount) |-> (errCount == '0 || errCount == $past(errCount) + 1'b1));

  // R12
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClr) |=> errFlag);

  // R12
  flag_on_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errCount != '0 && !$stable(errCount)) |-> errFlag);
endmodule

bind selftest_symbol_engine selftest_symbol_engine_chk #(.CNT_W(CNT_W)) chkInst (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .txTestEn(txTestEn), .errClr(errClr),
  .txSym(txSym), .txValid(txValid), .errCount(errCount), .errFlag(errFlag)
);

// File: tb/selftest_symbol_engine_test.sv
`timescale 1ns/1ps
module selftest_symbol_engine_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  modeSel = 3'b000;
  logic        txTestEn = 1'b0;
  logic        patWrEn = 1'b0;
  logic [19:0] patWrData = '0;
  logic        errClr = 1'b0;
  logic [9:0]  rxDrv = '0;
  logic        rxVDrv = 1'b0;
  logic        loopBack = 1'b0;
  logic [9:0]  rxSym;
  logic        rxValid;
  logic [9:0]  txSym;
  logic        txValid;
  logic [15:0] errCount;
  logic        errFlag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign rxSym   = loopBack ? txSym : rxDrv;
  assign rxValid = loopBack ? txValid : rxVDrv;

  selftest_symbol_engine uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .txTestEn(txTestEn),
    .patWrEn(patWrEn), .patWrData(patWrData), .errClr(errClr),
    .rxSym(rxSym), .rxValid(rxValid), .txSym(txSym), .txValid(txValid),
    .errCount(errCount), .errFlag(errFlag)
  );

  typedef struct {
    logic [9:0]  sym;
    logic        vld;
    logic [15:0] cnt;
    logic        flg;
    bit          cTx;
    bit          cErr;
    string       tag;
  } item_t;
  item_t q[$];

  // PRBS7 bit stream from the recurrence b[n] = b[n-7] ^ b[n-6]
  bit prbsBits[0:199];
  initial begin
    for (int n = 0; n < 7; n++) prbsBits[n] = 1'b1;
    for (int n = 7; n < 200; n++) prbsBits[n] = prbsBits[n-7] ^ prbsBits[n-6];
  end
  function automatic logic [9:0] prbsSym(input int k);
    logic [9:0] s;
    for (int i = 0; i < 10; i++) s[9-i] = prbsBits[7 + 10*k + i];
    return s;
  endfunction

  task automatic step(input logic [2:0] m, input logic t, input logic c,
                      input logic [9:0] rs, input logic rv);
    @(negedge clk);
    modeSel = m; txTestEn = t; errClr = c; rxDrv = rs; rxVDrv = rv;
  endtask

  task automatic pushItem(input logic [9:0] s, input logic v, input logic [15:0] n,
                          input logic f, input bit ct, input bit ce, input string tg);
    item_t it;
    it.sym = s; it.vld = v; it.cnt = n; it.flg = f; it.cTx = ct; it.cErr = ce; it.tag = tg;
    q.push_back(it);
  endtask

  // monitor: compares after each edge, one queued item per cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        if (it.cTx) begin
          checks++;
          if (txSym !== it.sym || txValid !== it.vld) begin
            failures++;
            $display("FAIL %s tx: got sym=%h valid=%b expected sym=%h valid=%b",
                     it.tag, txSym, txValid, it.sym, it.vld);
          end
        end
        if (it.cErr) begin
          checks++;
          if (errCount !== it.cnt || errFlag !== it.flg) begin
            failures++;
            $display("FAIL %s err: got cnt=%0d flag=%b expected cnt=%0d flag=%b",
                     it.tag, errCount, errFlag, it.cnt, it.flg);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got no finish expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (txValid !== 1'b0 || txSym !== 10'h000 || errCount !== 16'd0 || errFlag !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: got sym=%h valid=%b cnt=%0d flag=%b expected all zero",
               txSym, txValid, errCount, errFlag);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R1, R2: idle selects ignore received garbage
    for (int k = 0; k < 4; k++) begin
      step(3'b000, 1'b0, 1'b0, 10'h2AA, 1'b1);
      pushItem(10'h000, 1'b0, 16'd0, 1'b0, 1, 1, "R1 R2 sel000");
    end
    for (int k = 0; k < 4; k++) begin
      step(3'b001, 1'b0, 1'b0, 10'h155, 1'b1);
      pushItem(10'h000, 1'b0, 16'd0, 1'b0, 1, 1, "R2 sel001");
    end

    // R3: constant selects on a direct loop
    loopBack = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step(3'b100, 1'b0, 1'b0, 10'h0, 1'b0);
      pushItem(10'h000, 1'b1, 16'd0, 1'b0, 1, 1, "R3 zeros");
    end
    for (int k = 0; k < 6; k++) begin
      step(3'b010, 1'b0, 1'b0, 10'h0, 1'b0);
      pushItem(10'h3FF, 1'b1, 16'd0, 1'b0, 1, 1, "R3 ones");
    end
    for (int k = 0; k < 6; k++) begin
      step(3'b110, 1'b0, 1'b0, 10'h0, 1'b0);
      pushItem(10'h155, 1'b1, 16'd0, 1'b0, 1, 1, "R3 alt");
    end

    // R4: clean pair
    for (int k = 0; k < 8; k++) begin
      step(3'b101, 1'b0, 1'b0, 10'h0, 1'b0);
      pushItem((k % 2 == 0) ? 10'h0FA : 10'h305, 1'b1, 16'd0, 1'b0, 1, 1, "R4 pair");
    end

    // R5: corrupted pair counts every symbol from the second edge
    for (int k = 0; k < 10; k++) begin
      step(3'b011, 1'b0, 1'b0, 10'h0, 1'b0);
      pushItem((k % 2 == 0) ? 10'h0FB : 10'h304, 1'b1, 16'(k), (k >= 1), 1, 1, "R5 inject");
    end
    // R11: saturation
    for (int k = 0; k < 65600; k++) step(3'b011, 1'b0, 1'b0, 10'h0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      step(3'b011, 1'b0, 1'b0, 10'h0, 1'b0);
      pushItem(10'h0, 1'b0, 16'hFFFF, 1'b1, 0, 1, "R11 saturate");
    end

    // R11, R12: select change clears count not flag; errClr clears flag
    for (int k = 0; k < 7; k++) begin
      step(3'b101, 1'b0, (k == 4), 10'h0, 1'b0);
      pushItem(10'h0, 1'b0, 16'd0, (k < 4), 0, 1, "R12 clear");
    end

    // R6: PRBS on a direct loop
    for (int k = 0; k < 12; k++) begin
      step(3'b111, 1'b0, 1'b0, 10'h0, 1'b0);
      pushItem(prbsSym(k), 1'b1, 16'd0, 1'b0, 1, 1, "R6 prbs");
    end

    // R7: self-seeding, gap, one flipped bit
    loopBack = 1'b0;
    step(3'b100, 1'b0, 1'b0, 10'h0, 1'b0);
    step(3'b111, 1'b0, 1'b0, prbsSym(5), 1'b1);
    pushItem(10'h0, 1'b0, 16'd0, 1'b0, 0, 1, "R7 change edge");
    step(3'b111, 1'b0, 1'b0, prbsSym(6), 1'b1);
    pushItem(10'h0, 1'b0, 16'd0, 1'b0, 0, 1, "R7 seed");
    step(3'b111, 1'b0, 1'b0, prbsSym(7), 1'b1);
    pushItem(10'h0, 1'b0, 16'd0, 1'b0, 0, 1, "R7 track");
    step(3'b111, 1'b0, 1'b0, 10'h3C3, 1'b0);
    pushItem(10'h0, 1'b0, 16'd0, 1'b0, 0, 1, "R7 gap");
    step(3'b111, 1'b0, 1'b0, prbsSym(8), 1'b1);
    pushItem(10'h0, 1'b0, 16'd0, 1'b0, 0, 1, "R7 after gap");
    step(3'b111, 1'b0, 1'b0, prbsSym(9) ^ 10'h010, 1'b1);
    pushItem(10'h0, 1'b0, 16'd1, 1'b1, 0, 1, "R7 flipped");
    step(3'b111, 1'b0, 1'b0, prbsSym(10), 1'b1);
    pushItem(10'h0, 1'b0, 16'd1, 1'b1, 0, 1, "R7 recovered");

    // R8: alignment on bits [9:1]
    step(3'b110, 1'b0, 1'b0, 10'h0, 1'b0);
    step(3'b101, 1'b0, 1'b0, 10'h0FA, 1'b1);
    pushItem(10'h0, 1'b0, 16'd0, 1'b1, 0, 1, "R8 change edge");
    step(3'b101, 1'b0, 1'b0, 10'h2AA, 1'b1);
    pushItem(10'h0, 1'b0, 16'd0, 1'b1, 0, 1, "R8 unaligned");
    step(3'b101, 1'b0, 1'b0, 10'h304, 1'b1);
    pushItem(10'h0, 1'b0, 16'd1, 1'b1, 0, 1, "R8 align bad lsb");
    step(3'b101, 1'b0, 1'b0, 10'h0FA, 1'b1);
    pushItem(10'h0, 1'b0, 16'd1, 1'b1, 0, 1, "R8 next");
    step(3'b101, 1'b0, 1'b0, 10'h305, 1'b1);
    pushItem(10'h0, 1'b0, 16'd1, 1'b1, 0, 1, "R8 next2");

    // R9, R1: default programmed word
    for (int k = 0; k < 4; k++) begin
      step(3'b000, 1'b1, 1'b0, 10'h0, 1'b0);
      pushItem((k % 2 == 0) ? 10'h000 : 10'h3FF, 1'b1, 16'd0, 1'b1, 1, 0, "R9 R1 default word");
    end
    // R10: load a new word while the test send is off
    step(3'b000, 1'b0, 1'b0, 10'h0, 1'b0);
    patWrEn = 1'b1; patWrData = 20'hABCDE;
    pushItem(10'h000, 1'b0, 16'd0, 1'b0, 1, 0, "R2 txtest off");
    for (int k = 0; k < 4; k++) begin
      step(3'b100, 1'b1, 1'b0, 10'h0, 1'b0);
      patWrEn = 1'b0;
      pushItem((k % 2 == 0) ? 10'h2AF : 10'h0DE, 1'b1, 16'd0, 1'b0, 1, 0, "R10 R9 new word");
    end

    step(3'b000, 1'b0, 1'b0, 10'h0, 1'b0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule